// File: doc/BRIEF.md
# Lazy Atomic-Registration Synchronization Unit

This unit decides, for every synchronization access coming from a group of cores, whether any cache coherence work is needed at all. It keeps a small directory of atomic synchronization variables and, for each one, which core's private L1 currently holds its registration. A variable that is absent from the directory is registered at the shared L2. Plain written data never enters the directory. Flushes and invalidates are sent out only when the registration of the accessed atomic has to move. An access that finds the atomic already registered at the requesting core finishes with no coherence traffic.

When registration moves between two cores, the unit first tells the current owner to flush. It then tells the requester to invalidate, and it issues these commands one at a time over a single command port that waits for an acknowledge. An agent-scope access leaves registration at the L2. It invalidates the requester on an acquire and flushes it on a release. If some core owned the variable, that core is flushed first and the variable is handed back to the L2. When the directory is full, a round-robin victim is flushed and its slot is reused. Three counters sort the completed accesses by how much work they needed.

Top module: `lazy_sync_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` and `done_o` are 0, and all three counters are 0.
- R2: A work-group access to an atomic that is registered at the requesting core issues no command, and it still completes with a `done_o` pulse.
- R3: A work-group access to an atomic that is registered at the L2 issues exactly one command, an invalidate (`cmd_kind`=1) to the requester. The atomic then becomes registered at the requester.
- R4: A work-group access to an atomic that is registered at another core issues a flush (`cmd_kind`=0) to the owner. After that flush is acknowledged, it issues an invalidate to the requester. Registration then moves to the requester, and no command follows the invalidate.
- R5: Acquire and release accesses at work-group scope take the same actions, chosen only by where the atomic is registered.
- R6: An agent-scope access issues an invalidate to the requester on acquire and a flush to the requester on release, never the other kind. If a core owned the atomic, that owner is flushed first. The atomic is left registered at the L2, so the next work-group access to it behaves as in R3.
- R7: A work-group access to an atomic that is not in a full directory evicts slots in round-robin order starting at slot 0, where slots fill lowest-free first. It flushes the victim's owner, then invalidates the requester, and the victim returns to the L2.
- R8: While `cmd_valid` is 1 and `cmd_ack` is 0, `cmd_valid`, `cmd_kind` and `cmd_core` hold their values.
- R9: `done_o` is a one-cycle pulse, raised in the cycle after the last acknowledge, or two cycles after acceptance when no command is needed. `req_ready` is 1 only when no access is in progress.
- R10: Each completed access adds one to exactly one counter. `cnt_none` counts R2 accesses, `cnt_remote` counts R4 accesses, and `cnt_l2` counts R3, R6 and R7 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Synchronization access request |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_core | input | CORE_W | Requesting core index |
| req_addr | input | ADDR_W | Atomic variable address |
| req_release | input | 1 | 1 = release, 0 = acquire |
| req_agent | input | 1 | 1 = agent scope, 0 = work-group scope |
| cmd_valid | output | 1 | Coherence command pending |
| cmd_kind | output | 1 | 0 = flush, 1 = invalidate |
| cmd_core | output | CORE_W | Target core of the command |
| cmd_ack | input | 1 | Command carried out |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_none | output | CNT_W | Accesses needing no action |
| cnt_l2 | output | CNT_W | Accesses involving the L2 |
| cnt_remote | output | CNT_W | Core-to-core transfers |

## Verification
A wrong owner in the directory shows at the ports within the very next access to that address. The unit then sends a flush to the wrong core, or sends none where a transfer was due, and the command sequence is compared exactly. A stale valid bit or a misplaced round-robin pointer turns up as an unexpected eviction flush, or a missing one, once the directory fills. Every access is also checked against the counter that should advance, so a wrong classification is caught in the cycle after its `done_o`.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_CMD1, ST_CMD2, ST_DONE
  } lsync_state_e;

  typedef enum logic [1:0] {
    CLS_NONE, CLS_L2, CLS_REMOTE
  } lsync_cls_e;

  localparam logic CMD_FLUSH = 1'b0;
  localparam logic CMD_INV   = 1'b1;
endpackage

// File: rtl/lsync_owner_table.sv
module lsync_owner_table #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int CORE_W  = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [CORE_W-1:0] hit_owner,
  output logic              has_free,
  output logic [IDX_W-1:0]  free_idx,
  output logic [IDX_W-1:0]  victim_idx,
  output logic [CORE_W-1:0] victim_owner,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CORE_W-1:0] wr_owner,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              victim_adv
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [CORE_W-1:0]  own_q [ENTRIES];
  logic [IDX_W-1:0]   vic_q, vic_d;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && tag_q[i] == look_addr) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign hit_owner    = own_q[hit_idx];
  assign victim_idx   = vic_q;
  assign victim_owner = own_q[vic_q];

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (clr_en && clr_idx == IDX_W'(i)) vld_d[i] = 1'b0;
      if (wr_en && wr_idx == IDX_W'(i))   vld_d[i] = 1'b1;
    end
  end

  always_comb begin
    vic_d = vic_q;
    if (victim_adv) begin
      vic_d = (vic_q == IDX_W'(ENTRIES - 1)) ? '0 : vic_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      vic_q <= '0;
    end else begin
      vld_q <= vld_d;
      vic_q <= vic_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && wr_idx == IDX_W'(i)) begin
        tag_q[i] <= wr_addr;
        own_q[i] <= wr_owner;
      end
    end
  end
endmodule

// File: rtl/lsync_decider.sv
module lsync_decider
  import lsync_pkg::*;
#(
  parameter int CORE_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic              agent,
  input  logic              release_op,
  input  logic [CORE_W-1:0] core,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [CORE_W-1:0] hit_owner,
  input  logic              has_free,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  victim_idx,
  input  logic [CORE_W-1:0] victim_owner,
  output lsync_cls_e        cls,
  output logic              c1_en,
  output logic [CORE_W-1:0] c1_core,
  output logic              c2_en,
  output logic              c2_kind,
  output logic              upd_en,
  output logic              clr_en,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              evict
);
  always_comb begin
    cls     = CLS_L2;
    c1_en   = 1'b0;
    c1_core = hit_owner;
    c2_en   = 1'b1;
    c2_kind = CMD_INV;
    upd_en  = 1'b0;
    clr_en  = 1'b0;
    tgt_idx = hit_idx;
    evict   = 1'b0;
    if (agent) begin
      c2_kind = release_op ? CMD_FLUSH : CMD_INV;
      if (hit) begin
        clr_en = 1'b1;
        c1_en  = !(release_op && hit_owner == core);
      end
    end else if (hit && hit_owner == core) begin
      cls   = CLS_NONE;
      c2_en = 1'b0;
    end else if (hit) begin
      cls    = CLS_REMOTE;
      c1_en  = 1'b1;
      upd_en = 1'b1;
    end else if (has_free) begin
      upd_en  = 1'b1;
      tgt_idx = free_idx;
    end else begin
      c1_en   = 1'b1;
      c1_core = victim_owner;
      upd_en  = 1'b1;
      tgt_idx = victim_idx;
      evict   = 1'b1;
    end
  end
endmodule

// File: rtl/lsync_counters.sv
module lsync_counters
  import lsync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  lsync_cls_e       cls,
  output logic [CNT_W-1:0] cnt_none,
  output logic [CNT_W-1:0] cnt_l2,
  output logic [CNT_W-1:0] cnt_remote
);
  logic en_none, en_l2, en_rem;

  assign en_none = tick && cls == CLS_NONE;
  assign en_l2   = tick && cls == CLS_L2;
  assign en_rem  = tick && cls == CLS_REMOTE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_none   <= '0;
      cnt_l2     <= '0;
      cnt_remote <= '0;
    end else begin
      if (en_none) cnt_none   <= cnt_none + 1'b1;
      if (en_l2)   cnt_l2     <= cnt_l2 + 1'b1;
      if (en_rem)  cnt_remote <= cnt_remote + 1'b1;
    end
  end
endmodule

// File: rtl/lazy_sync_unit.sv
module lazy_sync_unit
  import lsync_pkg::*;
#(
  parameter int N_CORES  = 4,
  parameter int ADDR_W   = 16,
  parameter int ENTRIES  = 4,
  parameter int CNT_W    = 16,
  localparam int CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_release,
  input  logic              req_agent,
  output logic              cmd_valid,
  output logic              cmd_kind,
  output logic [CORE_W-1:0] cmd_core,
  input  logic              cmd_ack,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_none,
  output logic [CNT_W-1:0]  cnt_l2,
  output logic [CNT_W-1:0]  cnt_remote
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  lsync_state_e st_q, st_d;

  logic              acc_en;
  logic [CORE_W-1:0] core_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rel_q, agent_q;

  logic              plan_en;
  lsync_cls_e        cls_q;
  logic              c1_en_q, c2_en_q, c2_kind_q, upd_q, clr_q, evict_q;
  logic [CORE_W-1:0] c1_core_q;
  logic [IDX_W-1:0]  tgt_q;

  logic              t_hit, t_free;
  logic [IDX_W-1:0]  t_hit_idx, t_free_idx, t_vic_idx;
  logic [CORE_W-1:0] t_hit_own, t_vic_own;

  lsync_cls_e        d_cls;
  logic              d_c1_en, d_c2_en, d_c2_kind, d_upd, d_clr, d_evict;
  logic [CORE_W-1:0] d_c1_core;
  logic [IDX_W-1:0]  d_tgt;

  logic in_done;

  lsync_owner_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CORE_W(CORE_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .look_addr   (addr_q),
    .hit         (t_hit),
    .hit_idx     (t_hit_idx),
    .hit_owner   (t_hit_own),
    .has_free    (t_free),
    .free_idx    (t_free_idx),
    .victim_idx  (t_vic_idx),
    .victim_owner(t_vic_own),
    .wr_en       (in_done && upd_q),
    .wr_idx      (tgt_q),
    .wr_addr     (addr_q),
    .wr_owner    (core_q),
    .clr_en      (in_done && clr_q),
    .clr_idx     (tgt_q),
    .victim_adv  (in_done && evict_q)
  );

  lsync_decider #(.CORE_W(CORE_W), .IDX_W(IDX_W)) u_decide (
    .agent       (agent_q),
    .release_op  (rel_q),
    .core        (core_q),
    .hit         (t_hit),
    .hit_idx     (t_hit_idx),
    .hit_owner   (t_hit_own),
    .has_free    (t_free),
    .free_idx    (t_free_idx),
    .victim_idx  (t_vic_idx),
    .victim_owner(t_vic_own),
    .cls         (d_cls),
    .c1_en       (d_c1_en),
    .c1_core     (d_c1_core),
    .c2_en       (d_c2_en),
    .c2_kind     (d_c2_kind),
    .upd_en      (d_upd),
    .clr_en      (d_clr),
    .tgt_idx     (d_tgt),
    .evict       (d_evict)
  );

  lsync_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick      (in_done),
    .cls       (cls_q),
    .cnt_none  (cnt_none),
    .cnt_l2    (cnt_l2),
    .cnt_remote(cnt_remote)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_DECIDE;
      ST_DECIDE: st_d = d_c1_en ? ST_CMD1 : (d_c2_en ? ST_CMD2 : ST_DONE);
      ST_CMD1:   if (cmd_ack) st_d = c2_en_q ? ST_CMD2 : ST_DONE;
      ST_CMD2:   if (cmd_ack) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign acc_en  = (st_q == ST_IDLE) && req_valid;
  assign plan_en = (st_q == ST_DECIDE);
  assign in_done = (st_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      core_q  <= req_core;
      addr_q  <= req_addr;
      rel_q   <= req_release;
      agent_q <= req_agent;
    end
  end

  always_ff @(posedge clk) begin
    if (plan_en) begin
      cls_q     <= d_cls;
      c1_en_q   <= d_c1_en;
      c1_core_q <= d_c1_core;
      c2_en_q   <= d_c2_en;
      c2_kind_q <= d_c2_kind;
      upd_q     <= d_upd;
      clr_q     <= d_clr;
      tgt_q     <= d_tgt;
      evict_q   <= d_evict;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign cmd_valid = (st_q == ST_CMD1) || (st_q == ST_CMD2);
  assign cmd_kind  = (st_q == ST_CMD1) ? CMD_FLUSH : c2_kind_q;
  assign cmd_core  = (st_q == ST_CMD1) ? c1_core_q : core_q;
  assign done_o    = in_done;

  logic unused_c1;
  assign unused_c1 = c1_en_q;
endmodule

// File: rtl/lazy_sync_unit_chk.sv
module lazy_sync_unit_chk #(
  parameter int CORE_W = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_kind,
  input logic [CORE_W-1:0] cmd_core,
  input logic              cmd_ack,
  input logic              done_o,
  input logic [CNT_W-1:0]  cnt_none,
  input logic [CNT_W-1:0]  cnt_l2,
  input logic [CNT_W-1:0]  cnt_remote
);
  logic [CNT_W+1:0] total;
  assign total = {2'b00, cnt_none} + {2'b00, cnt_l2} + {2'b00, cnt_remote};

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_core));

  p_inv_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind && cmd_ack |=> !cmd_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !done_o);

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> total == $past(total) + 1'b1);

  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(cnt_none) && $stable(cnt_l2) && $stable(cnt_remote));
endmodule

bind lazy_sync_unit lazy_sync_unit_chk #(.CORE_W(CORE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .cmd_core  (cmd_core),
  .cmd_ack   (cmd_ack),
  .done_o    (done_o),
  .cnt_none  (cnt_none),
  .cnt_l2    (cnt_l2),
  .cnt_remote(cnt_remote)
);

// File: tb/lazy_sync_unit_tb_top.sv
module lazy_sync_unit_tb_top;
  localparam int CW = 2;
  localparam int AW = 16;
  localparam int NW = 16;
  localparam bit FL = 1'b0;
  localparam bit IV = 1'b1;
  localparam int K_NONE = 0, K_L2 = 1, K_REM = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_core = '0;
  logic [AW-1:0] req_addr = '0;
  logic          req_release = 1'b0;
  logic          req_agent = 1'b0;
  logic          cmd_valid;
  logic          cmd_kind;
  logic [CW-1:0] cmd_core;
  logic          cmd_ack = 1'b0;
  logic          done_o;
  logic [NW-1:0] cnt_none, cnt_l2, cnt_remote;

  int n_chk = 0;
  int n_bad = 0;
  int m_none = 0, m_l2 = 0, m_rem = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lazy_sync_unit #(.N_CORES(4), .ADDR_W(AW), .ENTRIES(4), .CNT_W(NW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .req_addr(req_addr), .req_release(req_release), .req_agent(req_agent),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_core(cmd_core),
    .cmd_ack(cmd_ack), .done_o(done_o),
    .cnt_none(cnt_none), .cnt_l2(cnt_l2), .cnt_remote(cnt_remote)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input int core, input logic [AW-1:0] addr, input bit rel,
                        input bit agent, input int dly, input int e_n,
                        input bit k1, input int c1, input bit k2, input int c2,
                        input int e_cls, input string req);
    int n = 0;
    int wc = 0;
    bit got = 1'b0;
    bit kd [4];
    int cr [4];
    @(negedge clk);
    req_core = CW'(core); req_addr = addr; req_release = rel; req_agent = agent;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 60 && !got; t++) begin
      @(negedge clk);
      cmd_ack = 1'b0;
      if (done_o) begin
        got = 1'b1;
      end else if (cmd_valid && n < 4) begin
        if (wc == 0) begin
          kd[n] = cmd_kind; cr[n] = int'(cmd_core);
        end else begin
          chk(cmd_kind == kd[n] && int'(cmd_core) == cr[n], "R8 held command",
              int'(cmd_core), cr[n]);
        end
        if (wc >= dly) begin cmd_ack = 1'b1; n++; wc = 0; end
        else wc++;
      end
    end
    chk(got, {req, " completion"}, int'(got), 1);
    chk(n == e_n, {req, " command count"}, n, e_n);
    if (n == e_n && e_n >= 1) begin
      chk(kd[0] == k1 && cr[0] == c1, {req, " first command kind*10+core"},
          int'(kd[0]) * 10 + cr[0], int'(k1) * 10 + c1);
    end
    if (n == e_n && e_n == 2) begin
      chk(kd[1] == k2 && cr[1] == c2, {req, " second command kind*10+core"},
          int'(kd[1]) * 10 + cr[1], int'(k2) * 10 + c2);
    end
    if (e_cls == K_NONE) m_none++;
    else if (e_cls == K_L2) m_l2++;
    else m_rem++;
    @(negedge clk);
    chk(!done_o && req_ready, "R9 single-cycle done, back to ready",
        int'(done_o), 0);
    chk(int'(cnt_none) == m_none && int'(cnt_l2) == m_l2 && int'(cnt_remote) == m_rem,
        "R10 counters none*10000+l2*100+remote",
        int'(cnt_none) * 10000 + int'(cnt_l2) * 100 + int'(cnt_remote),
        m_none * 10000 + m_l2 * 100 + m_rem);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(req_ready && !cmd_valid && !done_o, "R1 idle outputs", int'(req_ready), 1);
    chk(cnt_none == 0 && cnt_l2 == 0 && cnt_remote == 0, "R1 counters zero",
        int'(cnt_l2), 0);
  endtask

  task automatic t_local_and_l2();
    access(0, 16'h0100, 0, 0, 0, 1, IV, 0, 0, 0, K_L2, "R3 L2 acquire");
    access(0, 16'h0100, 1, 0, 0, 0, 0, 0, 0, 0, K_NONE, "R2 R5 local release");
    access(0, 16'h0100, 0, 0, 0, 0, 0, 0, 0, 0, K_NONE, "R2 R5 local acquire");
  endtask

  task automatic t_remote();
    access(1, 16'h0100, 0, 0, 0, 2, FL, 0, IV, 1, K_REM, "R4 remote acquire");
    access(2, 16'h0100, 1, 0, 3, 2, FL, 1, IV, 2, K_REM, "R4 R5 R8 remote release slow ack");
  endtask

  task automatic t_agent();
    access(3, 16'h0200, 0, 1, 0, 1, IV, 3, 0, 0, K_L2, "R6 agent acquire");
    access(3, 16'h0200, 0, 0, 0, 1, IV, 3, 0, 0, K_L2, "R6 stays at L2");
    access(3, 16'h0300, 1, 1, 0, 1, FL, 3, 0, 0, K_L2, "R6 agent release");
    access(3, 16'h0100, 0, 1, 0, 2, FL, 2, IV, 3, K_L2, "R6 agent takes from owner");
    access(0, 16'h0100, 0, 0, 0, 1, IV, 0, 0, 0, K_L2, "R6 returned to L2");
  endtask

  task automatic t_evict();
    access(1, 16'h0400, 0, 0, 0, 1, IV, 1, 0, 0, K_L2, "R3 fill slot 2");
    access(2, 16'h0500, 0, 0, 0, 1, IV, 2, 0, 0, K_L2, "R3 fill slot 3");
    access(1, 16'h0600, 0, 0, 0, 2, FL, 0, IV, 1, K_L2, "R7 evict slot 0");
    access(2, 16'h0100, 0, 0, 0, 2, FL, 3, IV, 2, K_L2, "R7 evict slot 1");
    access(3, 16'h0200, 0, 0, 0, 2, FL, 1, IV, 3, K_L2, "R7 evict slot 2");
    access(1, 16'h0600, 1, 0, 0, 0, 0, 0, 0, 0, K_NONE, "R7 R2 new owner kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local_and_l2();
    t_remote();
    t_agent();
    t_evict();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule